// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in-first-out buffer for 9-bit words. A producer writes on its own clock and a consumer reads on another, and the two clocks have no fixed frequency or phase relation. The storage is a register array whose depth is set by a parameter (64 words by default). Both pointers cross between the domains as Gray code through two-flop synchronizers. Full, half-full and almost-full are computed on the write side. Empty and almost-empty are computed on the read side.

Two threshold offsets set where the almost-empty and almost-full flags trip. A master reset loads both offsets with one of two preset values, chosen by a select pin, and latches the output timing mode. A partial reset clears the stored words and the pointers but keeps the offsets and the mode. Software can reprogram the offsets in two ways: over the data bus under a load strobe, or one bit at a time on a serial line. A retransmit pulse rewinds the read pointer so the stored data can be read again.

The output timing is one of two modes. In standard mode a read request fetches the next word. In fall-through mode the oldest word sits on the output with a ready flag and no request is needed to see it.

Top module: `dcfifo_flagged`

## Requirements
- R1: Words come out in the order they were written, with write and read clocks running independently. The write pointer seen by the read side changes by one Gray-code bit per accepted write.
- R2: In standard mode (`timing_sel`=0 at master reset), `empty_or` is 1 exactly when no word is stored. A `rd_en` sampled while not empty places the next word on `dout` at that read-clock edge. A `rd_en` while empty is ignored: `dout` holds and the read pointer does not move.
- R3: In fall-through mode (`timing_sel`=1 at master reset), `empty_or` means output-ready. The oldest word appears on `dout` with `empty_or`=1 without any `rd_en`. A `rd_en` consumes it, and `dout` holds while `rd_en` is low.
- R4: `full_ir` is 1 in standard mode when DEPTH words are stored. In fall-through mode it means input-ready and is its inverse. A write attempted while full is ignored.
- R5: `half_full` is 1 when the write-side word count exceeds DEPTH/2 (more than 32 by default).
- R6: `almost_empty` is 1 when the stored count (excluding a word held in the fall-through output stage) is at most the empty offset. `almost_full` is 1 when the write-side count is at least DEPTH minus the full offset.
- R7: Master reset clears all words. It sets both offsets to 7 when `ofs_sel`=0 or to 63 when `ofs_sel`=1.
- R8: With `load` high, each `wr_en` writes `din[5:0]` into an offset instead of storing a word. The first such write goes to the empty offset, the next to the full offset, and so on alternately.
- R9: With `ser_en` high and `load` low, each write-clock edge shifts `ser_in` into the offsets. The first six bits fill the empty offset LSB first and the next six fill the full offset LSB first.
- R10: Partial reset clears the stored words and pointers and keeps the programmed offsets and the timing mode.
- R11: A `retx` pulse rewinds the read pointer to the first location written since the last reset. Reads then replay the data in order. In fall-through mode the first word is back on `dout` after the second read-clock edge following the pulse.
- R12: The timing mode is taken from `timing_sel` while `mrst_n` is low and does not change until the next master reset.
- R13: `dout` reads as zero while `oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, synchronous in each domain |
| timing_sel | input | 1 | Output timing select sampled during master reset (1 = fall-through) |
| ofs_sel | input | 1 | Default offset select sampled during master reset (0 = 7, 1 = 63) |
| wr_en | input | 1 | Write request |
| din | input | 9 | Write data, also parallel offset value |
| load | input | 1 | Routes writes to the offset register |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data bit |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit pulse (read domain) |
| oe | input | 1 | Output enable; 0 forces dout to zero |
| dout | output | 9 | Read data |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | More than half the depth is stored |
| almost_full | output | 1 | Programmable almost-full flag |
| almost_empty | output | 1 | Programmable almost-empty flag |

## Verification
The bench goes after the exact flag boundaries: 32 against 33 words for half-full, the offset edge on both threshold flags, and 63 against 64 words for full. An off-by-one compare would move each of these flags one word early or late. It writes into a full buffer and reads an empty one, where a pointer that moved would drop or duplicate a word in the order check. It programs the offsets in parallel and serially and then issues a partial reset, so a design that swapped the two offsets, shifted from the wrong end or reloaded defaults on partial reset would trip the almost-empty flag at the wrong count. Retransmit is checked in both timing modes, and the timing-select pin is changed after reset, so a rewind to the wrong place or a mode that follows the live pin shows up as wrong data or wrong flag meaning.

// File: rtl/dcfifo_pkg.sv
// Shared helpers for the dual-clock FIFO: binary/Gray conversion.
// Assumes pointer widths are passed in by the caller as AW+1 bits.
package dcfifo_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes the input changes at most one bit per source-clock edge.
module dcfifo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock domain.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
// Inferred register-array storage: one write port on the write clock,
// asynchronous read port. Assumes the read side only addresses entries
// whose write has already been made visible through the pointer sync.
module dcfifo_ram #(
    parameter int AW = 6,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-domain control: write pointer, offset register (parallel and
// serial loading, reset defaults), full / half-full / almost-full flags.
// Assumes AW <= DW so an offset fits on the data bus, and that offsets
// are reprogrammed only while the read side is not relying on them.
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 9,
    parameter int OFS_LO = 7,
    parameter int OFS_HI = 63
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          timing_sel,
    input  logic          ofs_sel,
    input  logic          wr_en,
    input  logic          load,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic [AW-1:0] ae_ofs,
    output logic          full_ir,
    output logic          half_full,
    output logic          almost_full
);
    localparam logic [AW:0]   DEPTH_W = (AW+1)'(1 << AW);
    localparam logic [AW:0]   HALF_W  = (AW+1)'(1 << (AW - 1));
    localparam logic [AW-1:0] LO_W    = AW'(OFS_LO);
    localparam logic [AW-1:0] HI_W    = AW'(OFS_HI);

    logic [AW:0]     wbin, wbin_nxt, rbin_s, wcount;
    logic [2*AW-1:0] ofs;          // {full offset, empty offset}
    logic            full, fwft_w, ld_hi;
    logic [AW-1:0]   af_ofs;

    assign rbin_s   = (AW+1)'(gray2bin(32'(rgray_sync)));
    assign wcount   = wbin - rbin_s;
    assign full     = (wcount == DEPTH_W);
    assign mem_we   = wr_en && !load && !full;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nxt = wbin + (AW+1)'(mem_we);
    assign ae_ofs   = ofs[AW-1:0];
    assign af_ofs   = ofs[2*AW-1:AW];

    // Advance the binary write pointer and its registered Gray copy.
    always_ff @(posedge wclk) begin
        if (!mrst_n || !prst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= (AW+1)'(bin2gray(32'(wbin_nxt)));
        end
    end

    // Latch the output timing mode while master reset is held.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            fwft_w <= timing_sel;
        end
    end

    // Offset register: defaults on master reset, then parallel or serial loads.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            ofs   <= ofs_sel ? {HI_W, HI_W} : {LO_W, LO_W};
            ld_hi <= 1'b0;
        end else if (!prst_n) begin
            ld_hi <= 1'b0;
        end else if (load && wr_en) begin
            if (ld_hi) begin
                ofs[2*AW-1:AW] <= din[AW-1:0];
            end else begin
                ofs[AW-1:0] <= din[AW-1:0];
            end
            ld_hi <= !ld_hi;
        end else if (ser_en && !load) begin
            ofs <= {ser_in, ofs[2*AW-1:1]};
        end
    end

    assign full_ir     = fwft_w ? !full : full;
    assign half_full   = (wcount > HALF_W);
    assign almost_full = (wcount >= (DEPTH_W - {1'b0, af_ofs}));

    // R4: a write into a full buffer leaves the pointer where it was.
    a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (wr_en && !load && full) |=> $stable(wbin));

    // R8: an offset load never consumes a storage slot.
    a_r8_load_not_stored: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (load && wr_en) |=> $stable(wbin));

    // R1: the pointer handed to the other domain moves one Gray bit at a time.
    a_r1_gray_step: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        $onehot0(wgray ^ $past(wgray)));

    // R12: mode stays put between master resets.
    a_r12_mode_held_w: assert property (@(posedge wclk) disable iff (!mrst_n)
        mrst_n |=> $stable(fwft_w));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-domain control: read pointer, output register / fall-through stage,
// retransmit rewind, empty / output-ready and almost-empty flags.
// Assumes retransmit is used only while no more than DEPTH words have been
// written since the last reset, and that ae_ofs is quasi-static.
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 9
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          timing_sel,
    input  logic          rd_en,
    input  logic          retx,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] rdata,
    input  logic [AW-1:0] ae_ofs,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] q,
    output logic          empty_or,
    output logic          almost_empty
);
    logic [AW:0] rbin, rbin_nxt, wbin_s, rcount;
    logic        empty, fwft_r, valid, take;

    assign wbin_s = (AW+1)'(gray2bin(32'(wgray_sync)));
    assign rcount = wbin_s - rbin;
    assign empty  = (rcount == '0);
    assign raddr  = rbin[AW-1:0];

    // Decide whether a word leaves storage this cycle.
    always_comb begin
        if (retx) begin
            take = 1'b0;
        end else if (fwft_r) begin
            take = !empty && (!valid || rd_en);
        end else begin
            take = rd_en && !empty;
        end
        rbin_nxt = retx ? '0 : rbin + (AW+1)'(take);
    end

    // Latch the output timing mode while master reset is held.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            fwft_r <= timing_sel;
        end
    end

    // Pointer, output word and fall-through valid bit.
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n) begin
            rbin  <= '0;
            rgray <= '0;
            q     <= '0;
            valid <= 1'b0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= (AW+1)'(bin2gray(32'(rbin_nxt)));
            if (retx) begin
                valid <= 1'b0;
            end else if (take) begin
                q     <= rdata;
                valid <= 1'b1;
            end else if (rd_en) begin
                valid <= 1'b0;
            end
        end
    end

    assign empty_or     = fwft_r ? valid : empty;
    assign almost_empty = (rcount <= {1'b0, ae_ofs});

    // R2: a standard-mode read of an empty buffer moves nothing.
    a_r2_no_underflow: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (!fwft_r && rd_en && !retx && empty) |=> ($stable(rbin) && $stable(q)));

    // R11: retransmit lands the read pointer on the first location.
    a_r11_rewind: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        retx |=> (rbin == '0));

    // R3: a ready fall-through word waits on the output until consumed.
    a_r3_word_held: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        (fwft_r && valid && !rd_en && !retx) |=> (valid && $stable(q)));

    // R12: mode stays put between master resets.
    a_r12_mode_held_r: assert property (@(posedge rclk) disable iff (!mrst_n)
        mrst_n |=> $stable(fwft_r));
endmodule

// File: rtl/dcfifo_flagged.sv
// Top: dual-clock FIFO with programmable threshold flags, two output
// timing modes, partial reset and retransmit. Assumes both resets are
// held low for at least two edges of each clock.
module dcfifo_flagged #(
    parameter int AW     = 6,
    parameter int DW     = 9,
    parameter int OFS_LO = 7,
    parameter int OFS_HI = 63
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          timing_sel,
    input  logic          ofs_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          load,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic          rd_en,
    input  logic          retx,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          full_ir,
    output logic          empty_or,
    output logic          half_full,
    output logic          almost_full,
    output logic          almost_empty
);
    logic            clr_n, mem_we;
    logic [AW:0]     wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]   waddr, raddr, ae_ofs;
    logic [DW-1:0]   rdata, q;

    assign clr_n = mrst_n && prst_n;

    dcfifo_wr_ctl #(.AW(AW), .DW(DW), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)) u_wr (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .timing_sel(timing_sel),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .load(load), .ser_en(ser_en),
        .ser_in(ser_in), .din(din), .rgray_sync(rgray_s), .wgray(wgray),
        .waddr(waddr), .mem_we(mem_we), .ae_ofs(ae_ofs), .full_ir(full_ir),
        .half_full(half_full), .almost_full(almost_full)
    );

    dcfifo_sync #(.W(AW + 1)) u_r2w (.clk(wclk), .clr_n(clr_n), .d(rgray), .q(rgray_s));
    dcfifo_sync #(.W(AW + 1)) u_w2r (.clk(rclk), .clr_n(clr_n), .d(wgray), .q(wgray_s));

    dcfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    dcfifo_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .timing_sel(timing_sel),
        .rd_en(rd_en), .retx(retx), .wgray_sync(wgray_s), .rdata(rdata),
        .ae_ofs(ae_ofs), .rgray(rgray), .raddr(raddr), .q(q),
        .empty_or(empty_or), .almost_empty(almost_empty)
    );

    assign dout = oe ? q : '0;
endmodule

// File: tb/dcfifo_flagged_tb.sv
// Bench for dcfifo_flagged: directed corner cases plus a seeded random
// write/read mix, checked against a queue model and flag functions.
module dcfifo_flagged_tb_top;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH       = 64;

    logic       wclk = 0, rclk = 0;
    logic       mrst_n = 0, prst_n = 1, timing_sel = 0, ofs_sel = 0;
    logic       wr_en = 0, load = 0, ser_en = 0, ser_in = 0;
    logic       rd_en = 0, retx = 0, oe = 1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       full_ir, empty_or, half_full, almost_full, almost_empty;

    int         nvec = 0, nerr = 0;
    logic [8:0] mq[$];
    logic [8:0] hist[$];

    always #(WCLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    dcfifo_flagged dut_i (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .timing_sel(timing_sel), .ofs_sel(ofs_sel), .wr_en(wr_en), .din(din),
        .load(load), .ser_en(ser_en), .ser_in(ser_in), .rd_en(rd_en),
        .retx(retx), .oe(oe), .dout(dout), .full_ir(full_ir),
        .empty_or(empty_or), .half_full(half_full), .almost_full(almost_full),
        .almost_empty(almost_empty)
    );

    // Expected-flag functions derived from the requirements.
    function automatic int f_hf(int n);           return int'(n > DEPTH / 2); endfunction
    function automatic int f_ae(int n, int ofs);  return int'(n <= ofs); endfunction
    function automatic int f_af(int n, int ofs);  return int'(n >= DEPTH - ofs); endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic do_mrst(input logic fw, input logic os);
        timing_sel = fw; ofs_sel = os; mrst_n = 0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        mrst_n = 1;
        mq.delete(); hist.delete();
        settle();
    endtask

    task automatic do_prst();
        prst_n = 0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        prst_n = 1;
        mq.delete(); hist.delete();
        settle();
    endtask

    task automatic wr_raw(input logic [8:0] d);
        @(negedge wclk); wr_en = 1; din = d;
        @(posedge wclk); #1 wr_en = 0;
    endtask

    task automatic wr_n(input int n);
        for (int i = 0; i < n; i++) begin
            logic [8:0] d;
            d = 9'($urandom);
            wr_raw(d);
            mq.push_back(d); hist.push_back(d);
        end
    endtask

    task automatic rd_std(input string tag);
        logic [8:0] e;
        @(negedge rclk); rd_en = 1;
        @(posedge rclk); #1 rd_en = 0;
        @(negedge rclk);
        e = mq.pop_front();
        chk(tag, int'(dout), int'(e));
    endtask

    task automatic rd_fwft(input string tag);
        logic [8:0] e;
        @(negedge rclk);
        e = mq.pop_front();
        chk(tag, int'(dout), int'(e));
        rd_en = 1;
        @(posedge rclk); #1 rd_en = 0;
    endtask

    task automatic pulse_retx();
        @(negedge rclk); retx = 1;
        @(posedge rclk); #1 retx = 0;
    endtask

    task automatic par_load(input int ae, input int af);
        @(negedge wclk); load = 1; wr_en = 1; din = 9'(ae);
        @(negedge wclk); din = 9'(af);
        @(negedge wclk); load = 0; wr_en = 0;
    endtask

    task automatic ser_load(input int ae, input int af);
        logic [11:0] bits;
        bits = {6'(af), 6'(ae)};
        for (int i = 0; i < 12; i++) begin
            @(negedge wclk); ser_en = 1; ser_in = bits[i];
        end
        @(negedge wclk); ser_en = 0;
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge wclk);
        nerr++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [8:0] held;
        void'($urandom(32'd2024));

        // ---- Reset state, standard mode, default offsets 7 (R7, R2)
        do_mrst(0, 0);
        chk("R2 empty after reset", int'(empty_or), 1);
        chk("R4 not full after reset", int'(full_ir), 0);
        chk("R5 hf after reset", int'(half_full), 0);
        chk("R7 ae default 7 at 0 words", int'(almost_empty), 1);
        chk("R7 af at 0 words", int'(almost_full), 0);
        chk("R13 dout after reset", int'(dout), 0);

        // ---- Almost-empty around default offset 7 (R6, R7)
        wr_n(7); settle();
        chk("R2 not empty", int'(empty_or), 0);
        chk("R7 ae at 7 words", int'(almost_empty), f_ae(7, 7));
        wr_n(1); settle();
        chk("R7 ae at 8 words", int'(almost_empty), f_ae(8, 7));
        while (mq.size() > 0) rd_std("R1 order");
        settle();
        chk("R2 empty after drain", int'(empty_or), 1);

        // ---- Read while empty is ignored (R2)
        held = dout;
        @(negedge rclk); rd_en = 1;
        @(posedge rclk); #1 rd_en = 0;
        @(negedge rclk);
        chk("R2 dout held on empty read", int'(dout), int'(held));
        wr_n(1); settle();
        rd_std("R2 pointer unmoved by empty read");

        // ---- Output enable (R13)
        @(negedge rclk); oe = 0; #1;
        chk("R13 dout zero with oe low", int'(dout), 0);
        oe = 1;

        // ---- Fill to the boundaries (R4, R5, R6)
        do_mrst(0, 0);
        wr_n(32); settle();
        chk("R5 hf at 32", int'(half_full), f_hf(32));
        wr_n(1); settle();
        chk("R5 hf at 33", int'(half_full), f_hf(33));
        wr_n(23); settle();
        chk("R6 af at 56", int'(almost_full), f_af(56, 7));
        wr_n(1); settle();
        chk("R6 af at 57", int'(almost_full), f_af(57, 7));
        wr_n(6); settle();
        chk("R4 not full at 63", int'(full_ir), 0);
        wr_n(1); settle();
        chk("R4 full at 64", int'(full_ir), 1);
        wr_raw(9'h1AA); settle();   // ignored: not added to model
        while (mq.size() > 0) rd_std("R4 order after overflow attempt");
        settle();
        chk("R4 empty after 64 reads", int'(empty_or), 1);

        // ---- Random mix against the model (R1)
        for (int it = 0; it < 1500; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r < 2 && !full_ir) begin
                wr_n(1);
            end else if (r == 2 && !empty_or) begin
                rd_std("R1 random order");
            end else begin
                @(negedge wclk);
            end
            if (it % 250 == 249) begin
                settle();
                chk("R5 hf random", int'(half_full), f_hf(mq.size()));
                chk("R6 ae random", int'(almost_empty), f_ae(mq.size(), 7));
                chk("R6 af random", int'(almost_full), f_af(mq.size(), 7));
            end
        end
        settle();
        while (mq.size() > 0) rd_std("R1 random drain");

        // ---- Parallel load then partial reset keeps offsets (R8, R10)
        do_mrst(0, 0);
        par_load(10, 20); settle();
        chk("R8 load stores nothing", int'(empty_or), 1);
        wr_n(10); settle();
        chk("R8 ae at 10 with offset 10", int'(almost_empty), f_ae(10, 10));
        wr_n(34); settle();
        chk("R8 af at 44 with offset 20", int'(almost_full), f_af(44, 20));
        do_prst();
        chk("R10 empty after partial reset", int'(empty_or), 1);
        wr_n(10); settle();
        chk("R10 ae kept at 10 words", int'(almost_empty), f_ae(10, 10));
        wr_n(1); settle();
        chk("R10 ae kept at 11 words", int'(almost_empty), f_ae(11, 10));
        rd_std("R10 first word after partial reset");

        // ---- Serial load (R9)
        do_mrst(0, 0);
        ser_load(3, 5); settle();
        wr_n(3); settle();
        chk("R9 ae at 3 with offset 3", int'(almost_empty), f_ae(3, 3));
        wr_n(1); settle();
        chk("R9 ae at 4 with offset 3", int'(almost_empty), f_ae(4, 3));
        wr_n(54); settle();
        chk("R9 af at 58 with offset 5", int'(almost_full), f_af(58, 5));
        wr_n(1); settle();
        chk("R9 af at 59 with offset 5", int'(almost_full), f_af(59, 5));

        // ---- Second default pair (R7)
        do_mrst(0, 1);
        chk("R7 af at 0 with default 63", int'(almost_full), f_af(0, 63));
        wr_n(1); settle();
        chk("R7 af at 1 with default 63", int'(almost_full), f_af(1, 63));
        chk("R7 ae at 1 with default 63", int'(almost_empty), f_ae(1, 63));

        // ---- Retransmit, standard mode (R11)
        do_mrst(0, 0);
        wr_n(4); settle();
        rd_std("R11 pre-read"); rd_std("R11 pre-read");
        pulse_retx(); settle();
        mq.delete();
        foreach (hist[i]) mq.push_back(hist[i]);
        while (mq.size() > 0) rd_std("R11 replay standard");

        // ---- Fall-through mode, pin changed after reset (R3, R12)
        do_mrst(1, 0);
        timing_sel = 0;
        chk("R12 not ready while empty", int'(empty_or), 0);
        chk("R12 input ready after reset", int'(full_ir), 1);
        wr_n(1); settle();
        chk("R3 ready without read", int'(empty_or), 1);
        chk("R3 word falls through", int'(dout), int'(mq[0]));
        wr_n(2); settle();
        while (mq.size() > 0) rd_fwft("R3 fall-through order");
        settle();
        chk("R3 not ready after drain", int'(empty_or), 0);

        // ---- Retransmit, fall-through mode (R11)
        pulse_retx();
        @(negedge rclk); @(negedge rclk);
        chk("R11 ready after rewind", int'(empty_or), 1);
        chk("R11 first word back", int'(dout), int'(hist[0]));
        mq.delete();
        foreach (hist[i]) mq.push_back(hist[i]);
        while (mq.size() > 0) rd_fwft("R11 replay fall-through");

        // ---- Fall-through full: output stage plus DEPTH stored (R4)
        do_mrst(1, 0);
        wr_n(65); settle();
        chk("R4 input not ready", int'(full_ir), 0);
        while (mq.size() > 0) rd_fwft("R4 fall-through drain");
        settle();
        chk("R4 input ready again", int'(full_ir), 1);

        report();
    end
endmodule